// File: doc/BRIEF.md
# Matrix Keyboard Strobe Scanner

This block scans a 64-key switch matrix wired as eight strobe rows crossing eight sense columns. Rows are driven open-drain style: the output data for every row is tied low, and a row is pulled to ground only while its output enable is set. Undriven rows float high through external pull-ups. A pressed key joins its row to its column, so the column reads low only while that row is strobed.

A single start pulse launches a scan. The enable walks from row 0 upward, one row per step. After each strobe change, the block waits a programmable settle time before it samples the columns. The first sample holding any low column ends the scan. The block then releases all rows and raises a one-cycle valid pulse with a 6-bit key code, formed from the row index and the lowest low column. If all eight rows read all ones, the scan ends with a one-cycle no-key pulse instead. Debounce and multi-key rollover are left to the logic that consumes the codes.

Top module: `kbd_scan`

## Requirements
- R1: While and after reset, strobe_oe_o is all zero, and key_valid_o and no_key_o are low.
- R2: At most one bit of strobe_oe_o is set at any time. A scan enables bit 0 first, and each later step moves the enable up by exactly one position.
- R3: A scan whose result is found on row r, with settle value S, raises its result pulse (r+1)*(S+1) clock edges after the edge that captures start_i. A scan with no key raises its pulse after 8*(S+1) edges.
- R4: The key code is row*8+col: key_code_o[5:3] is the index of the strobed row and key_code_o[2:0] is the column index.
- R5: With several keys down, the lowest strobed row that shows a low column wins. Within that row, the lowest-numbered low column wins. The winning key is therefore the lowest row*8+col among the pressed keys.
- R6: When no column reads low on any of the eight rows, no_key_o pulses for one cycle and key_valid_o stays low.
- R7: key_valid_o and no_key_o each last one cycle and are never high together. In the cycle they are high, strobe_oe_o is all zero.
- R8: A start_i pulse that arrives while a scan is running is ignored. This includes a pulse captured on the same edge that concludes a scan. Such a pulse neither changes the result timing nor launches a new scan.
- R9: key_code_o holds its value from one valid pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that begins a scan when the block is idle |
| settle_i | input | 8 | Number of extra settle cycles after each strobe change |
| col_i | input | 8 | Column sense inputs; 0 means connected to the strobed row |
| strobe_oe_o | output | 8 | Row output enables; data is always 0, so 1 grounds the row |
| key_code_o | output | 6 | {row index, column index} of the detected key |
| key_valid_o | output | 1 | One-cycle pulse: a key was found |
| no_key_o | output | 1 | One-cycle pulse: all rows read all ones |

## Verification
Two events can fall on the same edge. One is the sample that concludes a scan, whether it finds a key or finds nothing on row 7. The other is a new start pulse. The bench raises start_i in the cycle before that final sample edge and in the middle of a scan. It then judges that the result latency matches (r+1)*(S+1), and that strobe_oe_o stays all zero afterwards instead of beginning a second walk. A behavioural matrix in the bench also drives the columns from the live enables. The bench sweeps every single key and a set of pseudo-random multi-key patterns, and predicts each code as the lowest pressed index.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/kbd_prio_enc.sv
// Lowest set bit index finder.
module kbd_prio_enc #(
  parameter int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/kbd_settle_cnt.sv
module kbd_settle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/kbd_scan.sv
module kbd_scan
  import kbd_scan_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int CNT_W = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int KW = RW + CW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic [COLS-1:0]  col_i,
  output logic [ROWS-1:0]  strobe_oe_o,
  output logic [KW-1:0]    key_code_o,
  output logic             key_valid_o,
  output logic             no_key_o
);
  scan_state_e     state_q;
  logic [ROWS-1:0] strobe_q;
  logic [KW-1:0]   code_q;
  logic            valid_q, nokey_q;
  logic            settled, col_hit, last_row, cnt_load;
  logic [RW-1:0]   row_idx;
  logic [CW-1:0]   col_idx;
  logic            row_any;

  assign last_row = strobe_q[ROWS-1];
  assign cnt_load = ((state_q == ST_IDLE) && start_i) ||
                    ((state_q == ST_SCAN) && settled && !col_hit && !last_row);

  kbd_settle_cnt #(.CNT_W(CNT_W)) u_settle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (settle_i),
    .zero_o     (settled)
  );

  // low column -> connected key
  kbd_prio_enc #(.W(COLS)) u_col_enc (
    .vec_i (~col_i),
    .idx_o (col_idx),
    .any_o (col_hit)
  );

  kbd_prio_enc #(.W(ROWS)) u_row_enc (
    .vec_i (strobe_q),
    .idx_o (row_idx),
    .any_o (row_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      strobe_q <= '0;
      code_q   <= '0;
      valid_q  <= 1'b0;
      nokey_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      nokey_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            strobe_q <= ROWS'(1);
            state_q  <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (settled) begin
            if (col_hit && row_any) begin
              code_q   <= {row_idx, col_idx};
              valid_q  <= 1'b1;
              strobe_q <= '0;
              state_q  <= ST_IDLE;
            end else if (last_row) begin
              nokey_q  <= 1'b1;
              strobe_q <= '0;
              state_q  <= ST_IDLE;
            end else begin
              strobe_q <= strobe_q << 1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign strobe_oe_o = strobe_q;
  assign key_code_o  = code_q;
  assign key_valid_o = valid_q;
  assign no_key_o    = nokey_q;
endmodule

// File: rtl/kbd_scan_chk.sv
module kbd_scan_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int KW   = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [COLS-1:0] col_i,
  input logic [ROWS-1:0] strobe_oe_o,
  input logic [KW-1:0]   key_code_o,
  input logic            key_valid_o,
  input logic            no_key_o
);
  localparam int CW = $clog2(COLS);

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_oe_o));

  a_r2_first_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_oe_o != '0 && $past(strobe_oe_o) == '0) |-> strobe_oe_o == ROWS'(1));

  a_r2_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_oe_o != '0 && $past(strobe_oe_o) != '0 && !$stable(strobe_oe_o))
      |-> strobe_oe_o == ($past(strobe_oe_o) << 1));

  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(key_valid_o && no_key_o));

  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_o || no_key_o) |-> strobe_oe_o == '0);

  a_r7_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);

  a_r7_nokey_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_key_o |=> !no_key_o);

  a_r4_row_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> (($past(strobe_oe_o) >> key_code_o[KW-1:CW]) & ROWS'(1)) == ROWS'(1));

  a_r4_col_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> (($past(col_i) >> key_code_o[CW-1:0]) & COLS'(1)) == COLS'(0));

  a_r9_code_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_o |-> $stable(key_code_o));
endmodule

bind kbd_scan kbd_scan_chk #(.ROWS(ROWS), .COLS(COLS), .KW(KW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .col_i       (col_i),
  .strobe_oe_o (strobe_oe_o),
  .key_code_o  (key_code_o),
  .key_valid_o (key_valid_o),
  .no_key_o    (no_key_o)
);

// File: tb/kbd_scan_bench.sv
module kbd_scan_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] settle_i = '0;
  logic [7:0] col_i;
  logic [7:0] strobe_oe_o;
  logic [5:0] key_code_o;
  logic       key_valid_o, no_key_o;
  logic [63:0] pressed = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  kbd_scan u_kbd_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .settle_i(settle_i),
    .col_i(col_i), .strobe_oe_o(strobe_oe_o), .key_code_o(key_code_o),
    .key_valid_o(key_valid_o), .no_key_o(no_key_o)
  );

  // switch matrix model: strobed row grounds columns of its pressed keys
  always_comb begin
    col_i = 8'hFF;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        if (pressed[r*8+c] && strobe_oe_o[r]) col_i[c] = 1'b0;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // runs one scan; ign_at >= 0 pulses start again at that negedge count
  task automatic run_scan(input int s, input int ign_at, input string tag);
    int n, exp_n, low, last_oe, bad_step;
    bit found;
    low = -1;
    for (int i = 63; i >= 0; i--) if (pressed[i]) low = i;
    exp_n = (low < 0) ? 8*(s+1) : ((low/8)+1)*(s+1);
    settle_i = 8'(s);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    // R2: first enabled row is bit 0
    check(strobe_oe_o == 8'h01 || exp_n == 0, {tag, " R2 first row"}, strobe_oe_o, 1);
    n = 0; found = 0; last_oe = strobe_oe_o; bad_step = 0;
    while (!found && n < 4000) begin
      @(negedge clk_i); n++;
      start_i = (n == ign_at);
      if (strobe_oe_o != 0 && strobe_oe_o != last_oe && strobe_oe_o != (last_oe << 1)) bad_step = 1;
      if (strobe_oe_o != 0) last_oe = strobe_oe_o;
      if (key_valid_o || no_key_o) found = 1;
    end
    start_i = 1'b0;
    check(!bad_step, {tag, " R2 step"}, bad_step, 0);
    check(n == exp_n, {tag, " R3 latency"}, n, exp_n);
    if (low < 0) begin
      check(no_key_o && !key_valid_o, {tag, " R6 no key"}, {no_key_o, key_valid_o}, 2);
    end else begin
      check(key_valid_o && key_code_o == 6'(low), {tag, " R4 R5 code"}, key_code_o, low);
    end
    check(strobe_oe_o == 0, {tag, " R7 release"}, strobe_oe_o, 0);
    @(negedge clk_i);
    check(!key_valid_o && !no_key_o, {tag, " R7 pulse"}, {key_valid_o, no_key_o}, 0);
    // R8: no second scan starts
    check(strobe_oe_o == 0, {tag, " R8 idle after"}, strobe_oe_o, 0);
  endtask

  initial begin
    longint unsigned st;
    logic [63:0] a, b;
    logic [5:0] held;
    #(CLK_PERIOD*3);
    @(negedge clk_i);
    check(strobe_oe_o == 0 && !key_valid_o && !no_key_o, "R1 in reset", strobe_oe_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(strobe_oe_o == 0 && !key_valid_o && !no_key_o, "R1 after reset", strobe_oe_o, 0);

    // single keys, all 64, two settle values
    for (int k = 0; k < 64; k++) begin
      pressed = 64'd1 << k;
      run_scan(0, -1, "single s0");
    end
    for (int k = 0; k < 64; k += 7) begin
      pressed = 64'd1 << k;
      run_scan(3, -1, "single s3");
    end

    // no key, several settle values
    pressed = '0;
    run_scan(0, -1, "none s0");
    run_scan(5, -1, "none s5");

    // R5 multi-key patterns
    pressed = (64'd1 << 45) | (64'd1 << 19); run_scan(1, -1, "R5 rows");
    pressed = (64'd1 << 23) | (64'd1 << 20) | (64'd1 << 17); run_scan(0, -1, "R5 cols");
    st = 64'h9E3779B97F4A7C15;
    for (int t = 0; t < 24; t++) begin
      st ^= st << 13; st ^= st >> 7; st ^= st << 17; a = st;
      st ^= st << 13; st ^= st >> 7; st ^= st << 17; b = st;
      pressed = a & b;
      if (t % 3 == 0) pressed = pressed & (pressed << 20);
      run_scan(t % 4, -1, "R5 random");
    end

    // R8: start mid-scan and on the concluding edge
    pressed = 64'd1 << 42; run_scan(2, 4, "R8 mid");
    pressed = '0; run_scan(0, 7, "R8 final edge none");
    pressed = 64'd1 << 58; run_scan(0, 7, "R8 final edge key");

    // R9: code holds across later no-key scan and idle time
    pressed = 64'd1 << 37; run_scan(0, -1, "R9 setup");
    held = key_code_o;
    pressed = '0; run_scan(1, -1, "R9 none");
    repeat (5) @(negedge clk_i);
    check(key_code_o == held, "R9 hold", key_code_o, held);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule